// File: doc/BRIEF.md
# Two-dimensional DMA address sequencer

This block produces the word-address stream for one DMA channel. Software loads a line length, a line pitch, a line count minus one and a control byte, then writes a word-granular start address. That write launches the walk: the sequencer presents one word address per beat on a valid/ready handshake. Each line covers consecutive words. The next line begins one pitch after the start of the previous one. After the last word of the last line, a single completion pulse is raised and the sequencer goes idle.

A line length of zero selects a circular ping-pong mode. The address steps through a region of pitch × (count + 1) words and returns to the start address, without end. An event pulse marks the end of each half of the region, and a flag tells which half just finished. An abort input stops either mode at once and silences any pending pulse. The bus master, the data path and the peripheral handshake sit outside this block.

The controller has three states. `ST_IDLE` leaves on *launch* to `ST_WALK` when the line length is non-zero, or to `ST_LOOP` when it is zero. `ST_WALK` returns to `ST_IDLE` on *final beat* (handshake of the last word of the last line) or on *abort*. `ST_LOOP` returns to `ST_IDLE` only on *abort*.

Top module: `dma2d_addr_seq`

## Requirements
- R1: After reset `beat_valid`, `done_pulse` and `half_evt` are all low and the sequencer is idle.
- R2: A cycle with `start_we` high while idle (and `abort` low) launches a run. In the next cycle `beat_valid` is high and `beat_addr` equals `start_addr`. A `start_we` while a run is in progress is ignored.
- R3: In walk mode (`cfg_xlen` non-zero), each line emits `cfg_xlen` consecutive word addresses. Line n starts at start + n × `cfg_width`.
- R4: A walk emits `cfg_ylen` + 1 lines. `cfg_ylen` = 0 gives exactly one line.
- R5: `done_pulse` is high for exactly one cycle, the cycle after the handshake of the final beat. `beat_valid` is low in that same cycle.
- R6: With `cfg_xlen` = 0, addresses run from start to start + `cfg_width` × (`cfg_ylen` + 1) − 1 and then wrap to start, with no completion pulse.
- R7: In loop mode, `half_evt` pulses for one cycle after the handshake of the last word of each half. `half_id` is 0 after the first half and 1 after the second.
- R8: Bit 5 of `cfg_ctrl` (1 = memory to device) drives `beat_dir`. Bit 4 (1 = 4-word bursts) drives `beat_burst4`. Both are captured at launch and held for the run.
- R9: While `beat_valid` is high and `beat_ready` is low, `beat_addr` holds. No address is skipped.
- R10: `abort` makes the sequencer idle in the next cycle, with no `done_pulse` or `half_evt` from that cycle's beat. It takes priority over a same-cycle launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Start-address write strobe, launches a run |
| start_addr | input | AW | Start address in words |
| cfg_xlen | input | XW | Words per line; 0 selects loop mode |
| cfg_width | input | XW | Line pitch in words |
| cfg_ylen | input | YW | Line count minus one |
| cfg_ctrl | input | 8 | Control byte: bit 5 direction, bit 4 burst mode |
| abort | input | 1 | Stop the run immediately |
| beat_valid | output | 1 | An address is offered |
| beat_ready | input | 1 | Consumer accepts the offered address |
| beat_addr | output | AW | Current word address |
| beat_dir | output | 1 | Captured direction |
| beat_burst4 | output | 1 | Captured burst mode |
| done_pulse | output | 1 | Walk completed |
| half_evt | output | 1 | Loop half boundary reached |
| half_id | output | 1 | Which half finished (0 first, 1 second) |

## Verification
The assertions assume that the configuration inputs are stable from the launch write onward. They also assume that a loop region holds an even number of words, at least two. The stimulus loads every field in the same cycle as `start_we` and uses loop regions of 4 and 8 words. The stall and abort properties assume `beat_ready` is free to drop at any time. The bench does this with a fixed ready pattern that refuses every third beat.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_LOOP = 2'd2
    } seq_state_e;

    localparam int CTRL_W         = 8;
    localparam int CTRL_DIR_BIT   = 5;
    localparam int CTRL_BURST_BIT = 4;

endpackage

// File: rtl/dma2d_fsm.sv
module dma2d_fsm
    import dma2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_we,
    input  logic       abort,
    input  logic       cfg_loop,
    input  logic       fire,
    input  logic       line_end,
    input  logic       last_line,
    input  logic       half_hit,
    input  logic       wrap_hit,
    output seq_state_e state_o,
    output logic       launch_o,
    output logic       done_o,
    output logic       half_evt_o,
    output logic       half_id_o
);

    seq_state_e state_q, state_d;
    logic       walk_final, loop_mark;
    logic       done_q, half_q, hid_q;

    always_comb begin
        launch_o   = (state_q == ST_IDLE) && start_we && !abort;
        walk_final = (state_q == ST_WALK) && fire && line_end && last_line;
        loop_mark  = (state_q == ST_LOOP) && fire && (half_hit || wrap_hit);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_o) state_d = cfg_loop ? ST_LOOP : ST_WALK;
            ST_WALK: if (abort || walk_final) state_d = ST_IDLE;
            ST_LOOP: if (abort) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            half_q <= 1'b0;
            hid_q  <= 1'b0;
        end else begin
            done_q <= walk_final && !abort;
            half_q <= loop_mark && !abort;
            if (loop_mark && !abort) hid_q <= wrap_hit;
        end
    end

    assign state_o    = state_q;
    assign done_o     = done_q;
    assign half_evt_o = half_q;
    assign half_id_o  = hid_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE)); // R5
    AST_HALF_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> (state_q == ST_LOOP)); // R7
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE && !done_q && !half_q)); // R10

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int XW = 16,
    parameter int YW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fire,
    input  logic [AW-1:0]     start_addr,
    input  logic [XW-1:0]     cfg_xlen,
    input  logic [XW-1:0]     cfg_width,
    input  logic [YW-1:0]     cfg_ylen,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    output logic [AW-1:0]     addr_o,
    output logic              line_end_o,
    output logic              last_line_o,
    output logic              half_hit_o,
    output logic              wrap_hit_o,
    output logic              dir_o,
    output logic              burst_o
);

    localparam int RW = XW + YW;

    logic [AW-1:0] base_q, addr_q;
    logic [XW-1:0] xcnt_q, xlen_q, width_q;
    logic [YW-1:0] ycnt_q, ylen_q;
    logic [RW-1:0] ofs_q, last_q, hlast_q, reg_len;
    logic          loop_q, dir_q, burst_q;

    assign reg_len = RW'(cfg_width) * (RW'(cfg_ylen) + RW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            xcnt_q  <= '0;
            ycnt_q  <= '0;
            ofs_q   <= '0;
            xlen_q  <= '0;
            width_q <= '0;
            ylen_q  <= '0;
            last_q  <= '0;
            hlast_q <= '0;
            loop_q  <= 1'b0;
            dir_q   <= 1'b0;
            burst_q <= 1'b0;
        end else if (load) begin
            base_q  <= start_addr;
            addr_q  <= start_addr;
            xcnt_q  <= '0;
            ycnt_q  <= '0;
            ofs_q   <= '0;
            xlen_q  <= cfg_xlen;
            width_q <= cfg_width;
            ylen_q  <= cfg_ylen;
            last_q  <= reg_len - RW'(1);
            hlast_q <= (reg_len >> 1) - RW'(1);
            loop_q  <= (cfg_xlen == '0);
            dir_q   <= cfg_ctrl[CTRL_DIR_BIT];
            burst_q <= cfg_ctrl[CTRL_BURST_BIT];
        end else if (fire) begin
            if (loop_q) begin
                if (ofs_q == last_q) begin
                    addr_q <= base_q;
                    ofs_q  <= '0;
                end else begin
                    addr_q <= addr_q + AW'(1);
                    ofs_q  <= ofs_q + RW'(1);
                end
            end else if (line_end_o) begin
                base_q <= base_q + AW'(width_q);
                addr_q <= base_q + AW'(width_q);
                xcnt_q <= '0;
                ycnt_q <= ycnt_q + YW'(1);
            end else begin
                addr_q <= addr_q + AW'(1);
                xcnt_q <= xcnt_q + XW'(1);
            end
        end
    end

    assign addr_o      = addr_q;
    assign line_end_o  = (xcnt_q == xlen_q - XW'(1));
    assign last_line_o = (ycnt_q == ylen_q);
    assign wrap_hit_o  = (ofs_q == last_q);
    assign half_hit_o  = (ofs_q == hlast_q);
    assign dir_o       = dir_q;
    assign burst_o     = burst_q;

    AST_LOOP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        loop_q |-> (ofs_q <= last_q)); // R6
    AST_XCNT_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_q && xlen_q != '0) |-> (xcnt_q < xlen_q)); // R3

endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int XW = 16,
    parameter int YW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic [AW-1:0]     start_addr,
    input  logic [XW-1:0]     cfg_xlen,
    input  logic [XW-1:0]     cfg_width,
    input  logic [YW-1:0]     cfg_ylen,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              abort,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [AW-1:0]     beat_addr,
    output logic              beat_dir,
    output logic              beat_burst4,
    output logic              done_pulse,
    output logic              half_evt,
    output logic              half_id
);

    seq_state_e state;
    logic       launch, fire, line_end, last_line, half_hit, wrap_hit;

    assign beat_valid = (state != ST_IDLE);
    assign fire       = beat_valid && beat_ready;

    dma2d_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_we   (start_we),
        .abort      (abort),
        .cfg_loop   (cfg_xlen == '0),
        .fire       (fire),
        .line_end   (line_end),
        .last_line  (last_line),
        .half_hit   (half_hit),
        .wrap_hit   (wrap_hit),
        .state_o    (state),
        .launch_o   (launch),
        .done_o     (done_pulse),
        .half_evt_o (half_evt),
        .half_id_o  (half_id)
    );

    dma2d_walk #(.AW(AW), .XW(XW), .YW(YW)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (launch),
        .fire        (fire),
        .start_addr  (start_addr),
        .cfg_xlen    (cfg_xlen),
        .cfg_width   (cfg_width),
        .cfg_ylen    (cfg_ylen),
        .cfg_ctrl    (cfg_ctrl),
        .addr_o      (beat_addr),
        .line_end_o  (line_end),
        .last_line_o (last_line),
        .half_hit_o  (half_hit),
        .wrap_hit_o  (wrap_hit),
        .dir_o       (beat_dir),
        .burst_o     (beat_burst4)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready && !abort) |=> (beat_valid && $stable(beat_addr))); // R9
    AST_LAUNCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we && !beat_valid && !abort) |=> (beat_valid && beat_addr == $past(start_addr))); // R2
    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && half_evt)); // R6

endmodule

// File: tb/dma2d_addr_seq_tb_top.sv
module dma2d_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_we = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] cfg_xlen = '0, cfg_width = '0, cfg_ylen = '0;
    logic [7:0]  cfg_ctrl = '0;
    logic        abort = 1'b0, beat_ready = 1'b0;
    logic        beat_valid, beat_dir, beat_burst4, done_pulse, half_evt, half_id;
    logic [31:0] beat_addr;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    dma2d_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_addr(start_addr),
        .cfg_xlen(cfg_xlen), .cfg_width(cfg_width), .cfg_ylen(cfg_ylen),
        .cfg_ctrl(cfg_ctrl), .abort(abort), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_dir(beat_dir),
        .beat_burst4(beat_burst4), .done_pulse(done_pulse), .half_evt(half_evt),
        .half_id(half_id)
    );

    // stimulus / expected-result table: start, xlen, width, ylen, ctrl, stall, beats, last addr
    localparam int NV = 5;
    localparam int V_START[NV] = '{'h40, 'h200, 'h10, 'h1000, 'h7};
    localparam int V_XLEN [NV] = '{4, 3, 5, 1, 2};
    localparam int V_WIDTH[NV] = '{4, 8, 5, 16, 3};
    localparam int V_YLEN [NV] = '{2, 3, 0, 4, 1};
    localparam int V_CTRL [NV] = '{'h20, 'h10, 'h30, 'h00, 'h20};
    localparam int V_STALL[NV] = '{0, 1, 0, 1, 1};
    localparam int V_BEATS[NV] = '{12, 12, 5, 5, 4};
    localparam int V_LAST [NV] = '{'h4B, 'h21A, 'h14, 'h1040, 'hB};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input int sa, input int xl, input int wd, input int yl, input int ct);
        start_addr = 32'(sa); cfg_xlen = 16'(xl); cfg_width = 16'(wd);
        cfg_ylen = 16'(yl); cfg_ctrl = 8'(ct); start_we = 1'b1;
        @(negedge clk);
        start_we = 1'b0;
    endtask

    task automatic run_vec(input int v);
        int idx = 0, k = 0, seen = 0, last = -1;
        bit prev_stall = 0;
        launch(V_START[v], V_XLEN[v], V_WIDTH[v], V_YLEN[v], V_CTRL[v]);
        chk(beat_dir == ((V_CTRL[v] >> 5) & 1), "R8 dir", beat_dir, (V_CTRL[v] >> 5) & 1);
        chk(beat_burst4 == ((V_CTRL[v] >> 4) & 1), "R8 burst", beat_burst4, (V_CTRL[v] >> 4) & 1);
        while (idx < V_XLEN[v] * (V_YLEN[v] + 1) && k < 200) begin
            int  expa = V_START[v] + (idx / V_XLEN[v]) * V_WIDTH[v] + (idx % V_XLEN[v]);
            bit  rdy  = (V_STALL[v] != 0) ? ((k % 3) != 1) : 1'b1;
            chk(beat_valid && beat_addr == 32'(expa), prev_stall ? "R9 stall hold" : "R3 line step",
                beat_addr, expa);
            chk(!done_pulse, "R5 early done", done_pulse, 0);
            beat_ready = rdy;
            if (rdy) begin seen++; last = int'(beat_addr); end
            prev_stall = !rdy;
            k++;
            @(negedge clk);
            if (rdy) idx++;
        end
        beat_ready = 1'b0;
        chk(seen == V_BEATS[v], "R4 beat count", seen, V_BEATS[v]);
        chk(last == V_LAST[v], "R4 last address", last, V_LAST[v]);
        chk(done_pulse && !beat_valid, "R5 done after final beat", {done_pulse, beat_valid}, 2'b10);
        @(negedge clk);
        chk(!done_pulse, "R5 done single cycle", done_pulse, 0);
    endtask

    task automatic run_loop(input int sa, input int wd, input int yl, input int n);
        int len = wd * (yl + 1);
        int hl  = len / 2;
        launch(sa, 0, wd, yl, 'h00);
        beat_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            bit eh = (i > 0) && (((i - 1) % hl) == hl - 1);
            chk(beat_valid && beat_addr == 32'(sa + (i % len)), "R6 loop address", beat_addr, sa + (i % len));
            chk(half_evt == eh, "R7 half event", half_evt, eh);
            if (eh) chk(half_id == (((i - 1) % len) == len - 1), "R7 half id", half_id,
                        ((i - 1) % len) == len - 1);
            chk(!done_pulse, "R6 no done in loop", done_pulse, 0);
            @(negedge clk);
        end
        // beat n ends a half; abort must suppress its event
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0; beat_ready = 1'b0;
        chk(!beat_valid && !half_evt, "R10 abort in loop", {beat_valid, half_evt}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !done_pulse && !half_evt, "R1 reset state",
            {beat_valid, done_pulse, half_evt}, 0);

        for (int v = 0; v < NV; v++) run_vec(v);

        run_loop('h100, 1, 7, 19);
        run_loop('h300, 1, 3, 9);

        // R2: start ignored while busy; R8: control captured at launch
        launch('h80, 4, 4, 0, 'h30);
        beat_ready = 1'b1;
        chk(beat_addr == 32'h80, "R2 launch address", beat_addr, 'h80);
        start_we = 1'b1; start_addr = 32'h999; cfg_ctrl = 8'h00;
        @(negedge clk);
        start_we = 1'b0;
        chk(beat_addr == 32'h81, "R2 start ignored while busy", beat_addr, 'h81);
        chk(beat_dir && beat_burst4, "R8 control held", {beat_dir, beat_burst4}, 2'b11);
        for (int i = 2; i < 4; i++) begin
            @(negedge clk);
            chk(beat_addr == 32'(32'h80 + i), "R3 tail beats", beat_addr, 'h80 + i);
        end
        @(negedge clk);
        beat_ready = 1'b0;
        chk(done_pulse, "R5 done", done_pulse, 1);
        @(negedge clk);

        // R10: abort on the final beat
        launch('h5, 1, 1, 0, 'h00);
        beat_ready = 1'b1; abort = 1'b1;
        @(negedge clk);
        abort = 1'b0; beat_ready = 1'b0;
        chk(!beat_valid && !done_pulse, "R10 abort on final beat", {beat_valid, done_pulse}, 0);

        // R10: abort beats a same-cycle launch
        start_we = 1'b1; abort = 1'b1; start_addr = 32'h44; cfg_xlen = 16'd2;
        @(negedge clk);
        start_we = 1'b0; abort = 1'b0;
        chk(!beat_valid, "R10 abort over launch", beat_valid, 0);
        @(negedge clk);
        chk(!beat_valid, "R10 still idle", beat_valid, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R5 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule